// File: doc/BRIEF.md
# Merging Write Buffer

This block sits between a write-through data cache and the next memory level. It absorbs stores so the processor does not wait for memory. Each of its four slots covers one aligned block of four 32-bit words. A slot keeps the block index, the four words and a per-word written mask. A store whose block already owns a slot that is not yet being sent is folded into that slot, so a run of stores to consecutive words costs one memory transaction instead of four.

Slots leave in arrival order over a request/acknowledge port. Each transaction carries the block index, all four word lanes and the mask of written words. Loads may probe the buffer and receive a buffered word one cycle later, so a load never returns stale data from memory. Addresses on the processor side are word addresses: the two low bits select the word inside a block, and the bits above them form the block index.

Top module: `wbuf_merge`

## Requirements
- R1: After reset, mem_req, st_stall and ld_hit are low and the buffer holds nothing.
- R2: A store whose block index matches a slot that is not draining writes into that slot. Four stores to word addresses 0x40, 0x41, 0x42 and 0x43 yield exactly one memory transaction, with mem_mask = 4'b1111.
- R3: A store to a word that is already valid in its slot replaces the earlier value. Memory receives the last value written.
- R4: Slots are sent oldest first, one transaction per slot. A transaction completes on a rising edge where mem_req and mem_ack are both high.
- R5: While mem_req is high, the outputs stay stable until the acknowledge. mem_blk is the block index. Word i of the block sits in mem_data[32*i+31:32*i]. mem_mask bit i is set exactly when word i was written, so the mask is never zero.
- R6: The oldest slot begins draining in any of three cases: a second slot is occupied, all four of its words are valid, or IDLE_LIMIT (8) consecutive cycles pass without a store touching it. mem_req rises within two cycles of that condition.
- R7: A store to the block of the slot being drained takes a new slot. The transaction in progress is not altered.
- R8: st_stall is high when st_en is high, no non-draining slot matches the store's block, and all four slots are occupied. A stalled store has no effect. A store that merges is accepted even when all slots are occupied.
- R9: A load (ld_en) of a word held valid in the buffer gives ld_hit high on the next cycle. ld_data comes from the youngest slot holding that word.
- R10: A load of a word that no slot holds valid gives ld_hit low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_en | input | 1 | Store request |
| st_addr | input | 14 | Store word address |
| st_data | input | 32 | Store data |
| st_stall | output | 1 | Store cannot be accepted this cycle |
| ld_en | input | 1 | Load probe request |
| ld_addr | input | 14 | Load word address |
| ld_hit | output | 1 | Probed word is buffered (one cycle after probe) |
| ld_data | output | 32 | Buffered word (valid with ld_hit) |
| mem_req | output | 1 | Block transaction pending |
| mem_blk | output | 12 | Block index of the transaction |
| mem_data | output | 128 | Four word lanes of the block |
| mem_mask | output | 4 | Written-word mask of the block |
| mem_ack | input | 1 | Memory takes the transaction |

## Verification
A corrupted slot mask or block index shows up on the memory port as a wrong mask, a wrong block or an extra transaction, as soon as that slot reaches the head. That is at most one idle window plus a few cycles after the store. A broken pointer or occupancy count shows up as out-of-order blocks, a lost store in the final memory image, or st_stall asserted or released at the wrong occupancy, on the very cycle of the next store. Faulty forwarding selection shows up on ld_hit and ld_data one cycle after the probe.

// File: rtl/wbuf_merge_pkg.sv
package wbuf_merge_pkg;

  typedef enum logic {
    DR_FILL = 1'b0,
    DR_SEND = 1'b1
  } drain_e;

endpackage

// File: rtl/wbuf_merge_cam.sv
module wbuf_merge_cam #(
  parameter int DEPTH = 4,
  parameter int WPB   = 4,
  parameter int BLKW  = 12,
  parameter int PW    = 2,
  parameter int WSEL  = 2
) (
  input  logic [DEPTH-1:0] occ,
  input  logic [DEPTH-1:0] mok,
  input  logic [BLKW-1:0]  blk [DEPTH],
  input  logic [WPB-1:0]   msk [DEPTH],
  input  logic [PW-1:0]    head,
  input  logic [BLKW-1:0]  st_blk,
  input  logic [BLKW-1:0]  ld_blk,
  input  logic [WSEL-1:0]  ld_w,
  output logic [DEPTH-1:0] st_vec,
  output logic             st_hit,
  output logic [PW-1:0]    st_idx,
  output logic             ld_any,
  output logic [PW-1:0]    ld_idx
);

  logic [DEPTH-1:0] ld_vec;
  logic [PW-1:0]    rank [DEPTH];
  logic [PW-1:0]    best;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign st_vec[g] = mok[g] && (blk[g] == st_blk);
    assign ld_vec[g] = occ[g] && (blk[g] == ld_blk) && msk[g][ld_w];
    assign rank[g]   = PW'(g) - head;
  end

  always_comb begin
    st_hit = 1'b0;
    st_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (st_vec[i]) begin
        st_hit = 1'b1;
        st_idx = PW'(i);
      end
    end
  end

  // youngest matching slot wins (largest distance from head)
  always_comb begin
    ld_any = 1'b0;
    ld_idx = '0;
    best   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ld_vec[i] && (!ld_any || rank[i] >= best)) begin
        ld_any = 1'b1;
        ld_idx = PW'(i);
        best   = rank[i];
      end
    end
  end

endmodule

// File: rtl/wbuf_merge_drain.sv
module wbuf_merge_drain
  import wbuf_merge_pkg::*;
#(
  parameter int WPB        = 4,
  parameter int CW         = 3,
  parameter int IDLE_LIMIT = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [CW-1:0]  count,
  input  logic [WPB-1:0] head_msk,
  input  logic           head_touch,
  input  logic           mem_ack,
  output logic           send,
  output logic           pop
);

  localparam int AGW = $clog2(IDLE_LIMIT + 1);

  drain_e         state;
  logic [AGW-1:0] age;
  logic           start;

  assign start = (count != '0) &&
                 ((count > CW'(1)) || (&head_msk) || (age >= AGW'(IDLE_LIMIT)));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= DR_FILL;
      age   <= '0;
    end else if (state == DR_SEND) begin
      if (mem_ack) begin
        state <= DR_FILL;
        age   <= '0;
      end
    end else begin
      if (start) state <= DR_SEND;
      if (count == '0 || head_touch) age <= '0;
      else if (age < AGW'(IDLE_LIMIT)) age <= age + AGW'(1);
    end
  end

  assign send = (state == DR_SEND);
  assign pop  = send && mem_ack;

  // R4: a transaction is only offered while a slot is occupied
  a_r4_drain_occupied: assert property (@(posedge clk) disable iff (rst)
    send |-> (count != '0));

endmodule

// File: rtl/wbuf_merge.sv
module wbuf_merge
  import wbuf_merge_pkg::*;
#(
  parameter int AW         = 14,
  parameter int DW         = 32,
  parameter int WPB        = 4,
  parameter int DEPTH      = 4,
  parameter int IDLE_LIMIT = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                st_en,
  input  logic [AW-1:0]       st_addr,
  input  logic [DW-1:0]       st_data,
  output logic                st_stall,
  input  logic                ld_en,
  input  logic [AW-1:0]       ld_addr,
  output logic                ld_hit,
  output logic [DW-1:0]       ld_data,
  output logic                mem_req,
  output logic [AW-$clog2(WPB)-1:0] mem_blk,
  output logic [WPB*DW-1:0]   mem_data,
  output logic [WPB-1:0]      mem_mask,
  input  logic                mem_ack
);

  localparam int WSEL = $clog2(WPB);
  localparam int BLKW = AW - WSEL;
  localparam int PW   = $clog2(DEPTH);
  localparam int CW   = $clog2(DEPTH + 1);

  logic [BLKW-1:0] e_blk [DEPTH];
  logic [WPB-1:0]  e_msk [DEPTH];
  logic [DW-1:0]   e_dat [DEPTH*WPB];

  logic [PW-1:0]   head, tail;
  logic [CW-1:0]   count;
  logic [PW-1:0]   rel [DEPTH];
  logic [DEPTH-1:0] occ, mok, st_vec;
  logic            st_hit, ld_any, send, pop;
  logic [PW-1:0]   st_idx, ld_idx, wr_idx;
  logic            st_go, alloc, head_touch;

  wire [BLKW-1:0] st_blk = st_addr[AW-1:WSEL];
  wire [WSEL-1:0] st_w   = st_addr[WSEL-1:0];
  wire [BLKW-1:0] ld_blk = ld_addr[AW-1:WSEL];
  wire [WSEL-1:0] ld_w   = ld_addr[WSEL-1:0];
  wire [WPB-1:0]  wbit   = WPB'(1) << st_w;

  for (genvar g = 0; g < DEPTH; g++) begin : g_occ
    assign rel[g] = PW'(g) - head;
    assign occ[g] = CW'(rel[g]) < count;
    assign mok[g] = occ[g] && !(send && (PW'(g) == head));
  end

  wbuf_merge_cam #(
    .DEPTH(DEPTH), .WPB(WPB), .BLKW(BLKW), .PW(PW), .WSEL(WSEL)
  ) u_cam (
    .occ(occ), .mok(mok), .blk(e_blk), .msk(e_msk), .head(head),
    .st_blk(st_blk), .ld_blk(ld_blk), .ld_w(ld_w),
    .st_vec(st_vec), .st_hit(st_hit), .st_idx(st_idx),
    .ld_any(ld_any), .ld_idx(ld_idx)
  );

  assign st_stall   = st_en && !st_hit && (count == CW'(DEPTH));
  assign st_go      = st_en && !st_stall;
  assign alloc      = st_go && !st_hit;
  assign wr_idx     = st_hit ? st_idx : tail;
  assign head_touch = st_go && (st_hit ? (st_idx == head) : (count == '0));

  wbuf_merge_drain #(
    .WPB(WPB), .CW(CW), .IDLE_LIMIT(IDLE_LIMIT)
  ) u_drain (
    .clk(clk), .rst(rst), .count(count), .head_msk(e_msk[head]),
    .head_touch(head_touch), .mem_ack(mem_ack), .send(send), .pop(pop)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      head   <= '0;
      tail   <= '0;
      count  <= '0;
      ld_hit <= 1'b0;
    end else begin
      if (alloc) tail <= tail + PW'(1);
      head   <= head + PW'(pop);
      count  <= count + CW'(alloc) - CW'(pop);
      ld_hit <= ld_en && ld_any;
    end
  end

  always_ff @(posedge clk) begin
    if (st_go) begin
      if (st_hit) begin
        e_msk[st_idx] <= e_msk[st_idx] | wbit;
      end else begin
        e_blk[tail] <= st_blk;
        e_msk[tail] <= wbit;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (st_go) e_dat[{wr_idx, st_w}] <= st_data;
    ld_data <= e_dat[{ld_idx, ld_w}];
  end

  assign mem_req  = send;
  assign mem_blk  = e_blk[head];
  assign mem_mask = e_msk[head];
  for (genvar w = 0; w < WPB; w++) begin : g_lane
    assign mem_data[w*DW +: DW] = e_dat[{head, WSEL'(w)}];
  end

  // R5: an offered transaction holds until it is taken
  a_r5_req_steady: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_blk) &&
                               $stable(mem_mask) && $stable(mem_data)));

  // R5: every sent block carries at least one written word
  a_r5_mask_live: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_mask != '0));

  // R2: at most one open slot per block
  a_r2_single_owner: assert property (@(posedge clk) disable iff (rst)
    $onehot0(st_vec));

  // R8: occupancy bounded, no slot taken while stalled
  a_r8_cap: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  a_r8_no_alloc_stalled: assert property (@(posedge clk) disable iff (rst)
    st_stall |=> (count <= $past(count)));

endmodule

// File: tb/wbuf_merge_bench.sv
`timescale 1ns/1ps
module wbuf_merge_bench;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         st_en = 1'b0;
  logic [13:0]  st_addr = '0;
  logic [31:0]  st_data = '0;
  logic         st_stall;
  logic         ld_en = 1'b0;
  logic [13:0]  ld_addr = '0;
  logic         ld_hit;
  logic [31:0]  ld_data;
  logic         mem_req;
  logic [11:0]  mem_blk;
  logic [127:0] mem_data;
  logic [3:0]   mem_mask;
  logic         mem_ack = 1'b0;

  wbuf_merge u_wbuf_merge (
    .clk(clk), .rst(rst), .st_en(st_en), .st_addr(st_addr), .st_data(st_data),
    .st_stall(st_stall), .ld_en(ld_en), .ld_addr(ld_addr), .ld_hit(ld_hit),
    .ld_data(ld_data), .mem_req(mem_req), .mem_blk(mem_blk), .mem_data(mem_data),
    .mem_mask(mem_mask), .mem_ack(mem_ack)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int ack_mode = 0;      // 0 hold, 1 always, 2 random, 3 single
  int txn_n = 0;
  logic [11:0]  lg_blk [64];
  logic [3:0]   lg_msk [64];
  logic [127:0] lg_dat [64];
  logic [31:0]  mem_img [32];
  logic [31:0]  exp_img [32];

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input logic [127:0] act, input logic [127:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // byte address in, word address on the port
  task automatic put(input logic [15:0] ba, input logic [31:0] d);
    st_en = 1'b1; st_addr = ba[15:2]; st_data = d;
    forever begin
      #1;
      if (!st_stall) break;
      @(negedge clk);
    end
    @(negedge clk);
    st_en = 1'b0;
    if (ba < 16'h80) exp_img[ba[6:2]] = d;
  endtask

  task automatic probe(input logic [15:0] ba, output logic hit, output logic [31:0] d);
    ld_en = 1'b1; ld_addr = ba[15:2];
    @(negedge clk);
    ld_en = 1'b0;
    hit = ld_hit; d = ld_data;
  endtask

  task automatic drain_all();
    ack_mode = 1;
    cyc(60);
    ack_mode = 0;
    cyc(2);
  endtask

  task automatic ack_one();
    ack_mode = 3;
    cyc(3);
  endtask

  // memory side: decide acknowledge after the falling edge, log what is taken
  initial begin
    bit go;
    for (int i = 0; i < 32; i++) mem_img[i] = '0;
    forever begin
      @(negedge clk);
      #2;
      mem_ack = 1'b0;
      go = 1'b0;
      if (mem_req) begin
        case (ack_mode)
          1: go = 1'b1;
          2: go = ($urandom % 3) == 0;
          3: begin go = 1'b1; ack_mode = 0; end
          default: go = 1'b0;
        endcase
      end
      if (go) begin
        mem_ack = 1'b1;
        if (txn_n < 64) begin
          lg_blk[txn_n] = mem_blk; lg_msk[txn_n] = mem_mask; lg_dat[txn_n] = mem_data;
        end
        txn_n++;
        if (mem_blk < 12'd8)
          for (int w = 0; w < 4; w++)
            if (mem_mask[w]) mem_img[{mem_blk[2:0], w[1:0]}] = mem_data[w*32 +: 32];
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic h;
    logic [31:0] d;
    int n0;
    void'($urandom(32'd4242));
    for (int i = 0; i < 32; i++) exp_img[i] = '0;
    cyc(5);
    rst = 1'b0;
    cyc(1);

    // R1 reset state
    chk_eq("R1 mem_req", mem_req, 0);
    chk_eq("R1 st_stall", st_stall, 0);
    chk_eq("R1 ld_hit", ld_hit, 0);
    probe(16'h0100, h, d);
    chk_eq("R1 empty probe", h, 0);

    // R2 / R6: four consecutive words merge, full mask starts drain
    put(16'h0100, 32'hA0); put(16'h0104, 32'hA1); put(16'h0108, 32'hA2); put(16'h010C, 32'hA3);
    cyc(2);
    chk_eq("R6 full mask drains", mem_req, 1);
    chk_eq("R2 merged block", mem_blk, 12'h010);
    chk_eq("R2 merged mask", mem_mask, 4'hF);
    chk_eq("R5 lanes", mem_data, {32'hA3, 32'hA2, 32'hA1, 32'hA0});
    n0 = txn_n;
    ack_one();
    cyc(15);
    chk_eq("R2 single transaction", txn_n - n0, 1);
    chk_eq("R2 nothing left", mem_req, 0);

    // R3 / R6 idle: overwrite a valid word, idle window opens drain
    put(16'h0200, 32'h11); put(16'h0200, 32'h22);
    cyc(4);
    chk_eq("R6 not before idle limit", mem_req, 0);
    cyc(8);
    chk_eq("R6 idle drain", mem_req, 1);
    chk_eq("R3 mask", mem_mask, 4'h1);
    chk_eq("R3 last value", mem_data[31:0], 32'h22);
    drain_all();

    // R4 / R6: second slot starts drain, oldest first
    put(16'h0300, 32'h30); put(16'h0404, 32'h41);
    cyc(2);
    chk_eq("R6 second slot drains", mem_req, 1);
    chk_eq("R4 oldest first blk", mem_blk, 12'h030);
    chk_eq("R4 oldest first mask", mem_mask, 4'h1);
    ack_one();
    cyc(3);
    chk_eq("R6 idle restarts after pop", mem_req, 0);
    cyc(12);
    chk_eq("R4 next blk", mem_blk, 12'h040);
    chk_eq("R4 next mask", mem_mask, 4'h2);
    chk_eq("R4 next req", mem_req, 1);
    drain_all();

    // R7: store to draining block takes a fresh slot
    put(16'h0500, 32'h50);
    cyc(12);
    chk_eq("R7 draining", mem_req, 1);
    put(16'h0504, 32'h51);
    cyc(2);
    chk_eq("R7 mask untouched", mem_mask, 4'h1);
    chk_eq("R7 data untouched", mem_data[31:0], 32'h50);
    ack_one();
    cyc(14);
    chk_eq("R7 new slot blk", mem_blk, 12'h050);
    chk_eq("R7 new slot mask", mem_mask, 4'h2);
    chk_eq("R7 new slot data", mem_data[63:32], 32'h51);
    drain_all();

    // R8: stall when full, merge still accepted, stalled store dropped
    n0 = txn_n;
    put(16'h0600, 32'h60); put(16'h0610, 32'h61); put(16'h0620, 32'h62); put(16'h0630, 32'h63);
    st_en = 1'b1; st_addr = 16'h0640 >> 2; st_data = 32'h64;
    #1;
    chk_eq("R8 stall full", st_stall, 1);
    cyc(3);
    st_addr = 16'h0614 >> 2; st_data = 32'h65;
    #1;
    chk_eq("R8 merge not stalled", st_stall, 0);
    @(negedge clk);
    st_en = 1'b0;
    drain_all();
    chk_eq("R8 transaction count", txn_n - n0, 4);
    chk_eq("R4 order 0", lg_blk[n0],     12'h060);
    chk_eq("R4 order 1", lg_blk[n0 + 1], 12'h061);
    chk_eq("R4 order 2", lg_blk[n0 + 2], 12'h062);
    chk_eq("R4 order 3", lg_blk[n0 + 3], 12'h063);
    chk_eq("R8 merged into full", lg_msk[n0 + 1], 4'h3);

    // R9 / R10: forwarding
    put(16'h0700, 32'h70); put(16'h0708, 32'h72);
    probe(16'h0708, h, d);
    chk_eq("R9 hit", h, 1);
    chk_eq("R9 data", d, 32'h72);
    probe(16'h0704, h, d);
    chk_eq("R10 invalid word", h, 0);
    probe(16'h0800, h, d);
    chk_eq("R10 other block", h, 0);
    cyc(12);
    put(16'h0700, 32'h7A);
    probe(16'h0700, h, d);
    chk_eq("R9 youngest hit", h, 1);
    chk_eq("R9 youngest data", d, 32'h7A);
    probe(16'h0708, h, d);
    chk_eq("R9 older slot data", d, 32'h72);
    drain_all();

    // random traffic on blocks 0..7 with random acknowledge
    ack_mode = 2;
    for (int k = 0; k < 300; k++) begin
      cyc($urandom % 3);
      put(16'(($urandom % 32) * 4), $urandom);
    end
    drain_all();
    for (int i = 0; i < 32; i++)
      chk_eq($sformatf("R3 R4 image word %0d", i), mem_img[i], exp_img[i]);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule